// File: doc/BRIEF.md
# Host Register Bank Serial Slave

This block lets a host microcontroller reach a 64-byte register space over a four-wire clocked serial link (serial clock, select, data in, data out). The space holds the decoder's stream information bytes, one burst information byte, two status bytes, a 16-bit read pointer, a 16-bit write pointer, a bank of control bytes and one test byte. Contents of the read-only bytes are supplied by the decoder logic on input buses. The block keeps the status bytes, the read pointer and the control bytes itself, and it applies each byte's host write permission.

Two of these chips can share one serial link in a dual-stream system. A role input places the chip either in the lower window (host addresses 0x00 to 0x3F) or the upper window (0x40 to 0x7F). Inside its window a chip sees the same local layout in both roles. A strap input chooses this serial link or a two-wire alternative. When the alternative is chosen the serial pins are ignored. All serial pins are resynchronised into the system clock, so each half period of the serial clock must last at least four system clocks.

Top module: `hreg_serial_slave`

## Requirements
- R1: While `if_sel` is 1, serial traffic has no effect: no register changes and `so_oe` stays 0.
- R2: A frame starts with `ss_n` falling. The first byte is a command: bit 7 is 1 for read and 0 for write, and bits 6:0 are the host address. One data byte follows. Every byte is MSB first and is sampled on the rising edge of `sck`. A write takes effect only after the 16th rising edge, and a frame that ends before that changes nothing.
- R3: With `chip_role` 0 the chip answers host addresses 0x00–0x3F, and with `chip_role` 1 it answers 0x40–0x7F at local address = host address minus 0x40. A write outside the window changes nothing. During a read outside the window, `so_oe` stays 0.
- R4: For an in-window read, `so_oe` rises after the command byte. The addressed byte appears on `so` MSB first, with each bit valid before the rising `sck` edges 9 to 16.
- R5: Local 0x14 to 0x14+CTRL_BYTES-1 are control bytes that can be read and written. Byte i appears on `ctrl_o[8i+7:8i]`. All control bytes reset to 0.
- R6: Local 0x10 holds the read pointer high byte and 0x11 holds its low byte. The host may write them only while `dec_busy` is 0. The pointer drives `rptr_o` and resets to 0. A `rp_ld` pulse loads `rp_i`.
- R7: Local 0x12 and 0x13 return the high and low bytes of `wptr_i`, and host writes to them are ignored.
- R8: Local 0x00–0x0D return `info_i[8n+7:8n]` for local address n, and host writes to them are ignored.
- R9: Local 0x0E and 0x0F are status bytes that reset to 0x03 and 0x00. In byte 0x0E, bit 0 set means not locked and bit 1 set means no sync word was seen. A `stat_we` pulse loads `stat0_i` and `stat1_i`, and host writes to these bytes are ignored.
- R10: Local 0x14+CTRL_BYTES returns `test_i` and ignores writes. All higher local addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_sel | input | 1 | 0 selects this serial link, 1 the two-wire alternative |
| chip_role | input | 1 | 0 lower address window, 1 upper window |
| dec_busy | input | 1 | Decoder is running; read pointer host-locked |
| sck | input | 1 | Serial clock from host, idle low |
| ss_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for `so`; 0 means released |
| info_i | input | 112 | Stream and burst information bytes 0x00–0x0D |
| stat_we | input | 1 | Load strobe for status bytes |
| stat0_i | input | 8 | New value of status byte 0x0E |
| stat1_i | input | 8 | New value of status byte 0x0F |
| rp_ld | input | 1 | Decoder load strobe for the read pointer |
| rp_i | input | 16 | Read pointer value to load |
| rptr_o | output | 16 | Current read pointer |
| wptr_i | input | 16 | Write pointer from the decoder |
| test_i | input | 8 | Test byte (overflow and underflow monitor) |
| ctrl_o | output | 8*CTRL_BYTES | Control bytes, byte i at bits 8i+7:8i |

## Verification
The bench uses the default parameters. CTRL_BYTES is 36, so the last control byte at local 0x37 sits directly below the test byte at 0x38, and the bench can probe both sides of that edge. SYNC_STAGES is 2, and the bench runs a serial half period of eight system clocks, which covers the synchroniser delay with some margin. It runs the random phase with both role settings, so the same stored bytes are reached through both windows and out-of-window probes fall on the other chip's range.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  localparam int ADDR_W     = 7;
  localparam int LOC_W      = 6;
  localparam int INFO_BYTES = 14;
  localparam int CTRL_BASE  = 20;

  localparam logic [LOC_W-1:0] LOC_STAT0 = 6'h0E;
  localparam logic [LOC_W-1:0] LOC_STAT1 = 6'h0F;
  localparam logic [LOC_W-1:0] LOC_RP_HI = 6'h10;
  localparam logic [LOC_W-1:0] LOC_RP_LO = 6'h11;
  localparam logic [LOC_W-1:0] LOC_WP_HI = 6'h12;
  localparam logic [LOC_W-1:0] LOC_WP_LO = 6'h13;

  localparam logic [7:0] STAT0_RST = 8'h03;
  localparam logic [7:0] STAT1_RST = 8'h00;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic role);
    return a[ADDR_W-1] == role;
  endfunction

  function automatic logic is_ctrl(input logic [LOC_W-1:0] loc, input int nbytes);
    return (int'(loc) >= CTRL_BASE) && (int'(loc) < CTRL_BASE + nbytes);
  endfunction

  function automatic logic host_may_write(input logic [LOC_W-1:0] loc, input logic busy,
                                          input int nbytes);
    return is_ctrl(loc, nbytes) || (((loc == LOC_RP_HI) || (loc == LOC_RP_LO)) && !busy);
  endfunction

endpackage

// File: rtl/hreg_sync.sv
module hreg_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hreg_frame.sv
module hreg_frame
  import hreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act,
  input  logic       sck_s,
  input  logic       si_s,
  input  logic       hit,
  input  logic [7:0] rdata,
  output cmd_t       cmd,
  output logic       wr_stb,
  output logic [7:0] wdata,
  output logic       so,
  output logic       so_oe
);
  logic       sck_d;
  logic [4:0] bit_cnt;
  logic [7:0] sh_in;
  logic [7:0] out_sh;
  logic       load_pend;
  logic       oe_q;
  cmd_t       cmd_q;

  // named edge events, visible to the assertions
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      bit_cnt   <= '0;
      sh_in     <= '0;
      out_sh    <= '0;
      load_pend <= 1'b0;
      oe_q      <= 1'b0;
      cmd_q     <= '0;
      wr_stb    <= 1'b0;
    end else begin
      sck_d     <= sck_s;
      wr_stb    <= 1'b0;
      load_pend <= 1'b0;
      if (!act) begin
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (sck_rise && bit_cnt < 5'd16) begin
          sh_in   <= {sh_in[6:0], si_s};
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == 5'd7) begin
            cmd_q     <= {sh_in[6:0], si_s};
            load_pend <= 1'b1;
          end
          if (bit_cnt == 5'd15 && !cmd_q.rd) wr_stb <= 1'b1;
        end
        if (load_pend && cmd_q.rd && hit) begin
          out_sh <= rdata;
          oe_q   <= 1'b1;
        end
        if (sck_fall && oe_q && bit_cnt >= 5'd9) out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end

  assign cmd   = cmd_q;
  assign wdata = sh_in;
  assign so_oe = oe_q;
  assign so    = oe_q & out_sh[7];

  assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !oe_q);
  assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 5'd16);
  assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_write_needs_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bit_cnt == 5'd16));
endmodule

// File: rtl/hreg_regfile.sv
module hreg_regfile
  import hreg_pkg::*;
#(
  parameter int CTRL_BYTES = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    role,
  input  logic                    busy,
  input  logic                    wr_stb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic [8*INFO_BYTES-1:0] info_i,
  input  logic                    stat_we,
  input  logic [7:0]              stat0_i,
  input  logic [7:0]              stat1_i,
  input  logic                    rp_ld,
  input  logic [15:0]             rp_i,
  input  logic [15:0]             wptr_i,
  input  logic [7:0]              test_i,
  output logic [7:0]              rdata,
  output logic [15:0]             rptr_o,
  output logic [8*CTRL_BYTES-1:0] ctrl_o
);
  localparam int TEST_LOC = CTRL_BASE + CTRL_BYTES;

  logic [7:0]  stat0_q, stat1_q;
  logic [15:0] rptr_q;
  logic [7:0]  ctrl_q [CTRL_BYTES];

  wire [LOC_W-1:0] loc = addr[LOC_W-1:0];
  // accepted host write, after window and permission
  wire wr_ok = wr_stb & in_window(addr, role) & host_may_write(loc, busy, CTRL_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat0_q <= STAT0_RST;
      stat1_q <= STAT1_RST;
    end else if (stat_we) begin
      stat0_q <= stat0_i;
      stat1_q <= stat1_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
    end else if (rp_ld) begin
      rptr_q <= rp_i;
    end else if (wr_ok && loc == LOC_RP_HI) begin
      rptr_q[15:8] <= wdata;
    end else if (wr_ok && loc == LOC_RP_LO) begin
      rptr_q[7:0] <= wdata;
    end
  end

  for (genvar i = 0; i < CTRL_BYTES; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= '0;
      else if (wr_ok && int'(loc) == CTRL_BASE + i) ctrl_q[i] <= wdata;
    end
    assign ctrl_o[8*i +: 8] = ctrl_q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < INFO_BYTES; i++)
      if (int'(loc) == i) rdata = info_i[8*i +: 8];
    for (int i = 0; i < CTRL_BYTES; i++)
      if (int'(loc) == CTRL_BASE + i) rdata = ctrl_q[i];
    if (loc == LOC_STAT0) rdata = stat0_q;
    if (loc == LOC_STAT1) rdata = stat1_q;
    if (loc == LOC_RP_HI) rdata = rptr_q[15:8];
    if (loc == LOC_RP_LO) rdata = rptr_q[7:0];
    if (loc == LOC_WP_HI) rdata = wptr_i[15:8];
    if (loc == LOC_WP_LO) rdata = wptr_i[7:0];
    if (int'(loc) == TEST_LOC) rdata = test_i;
  end

  assign rptr_o = rptr_q;

  assert_ptr_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rp_ld) |=> $stable(rptr_q));
  assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !in_window(addr, role)) |=> $stable(ctrl_o));
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ($stable(stat0_q) && $stable(stat1_q)));
  assert_info_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (loc >= LOC_RP_HI));
endmodule

// File: rtl/hreg_serial_slave.sv
module hreg_serial_slave
  import hreg_pkg::*;
#(
  parameter int CTRL_BYTES  = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    if_sel,
  input  logic                    chip_role,
  input  logic                    dec_busy,
  input  logic                    sck,
  input  logic                    ss_n,
  input  logic                    si,
  output logic                    so,
  output logic                    so_oe,
  input  logic [8*INFO_BYTES-1:0] info_i,
  input  logic                    stat_we,
  input  logic [7:0]              stat0_i,
  input  logic [7:0]              stat1_i,
  input  logic                    rp_ld,
  input  logic [15:0]             rp_i,
  output logic [15:0]             rptr_o,
  input  logic [15:0]             wptr_i,
  input  logic [7:0]              test_i,
  output logic [8*CTRL_BYTES-1:0] ctrl_o
);
  logic [2:0] pins_s;
  cmd_t       cmd;
  logic       wr_stb;
  logic [7:0] wdata, rdata;

  hreg_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, ss_n, si}), .q(pins_s)
  );

  wire frame_act = ~pins_s[1] & ~if_sel;
  wire addr_hit  = in_window(cmd.addr, chip_role);

  hreg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .act(frame_act), .sck_s(pins_s[2]), .si_s(pins_s[0]),
    .hit(addr_hit), .rdata(rdata), .cmd(cmd), .wr_stb(wr_stb), .wdata(wdata),
    .so(so), .so_oe(so_oe)
  );

  hreg_regfile #(.CTRL_BYTES(CTRL_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .role(chip_role), .busy(dec_busy), .wr_stb(wr_stb),
    .addr(cmd.addr), .wdata(wdata), .info_i(info_i), .stat_we(stat_we),
    .stat0_i(stat0_i), .stat1_i(stat1_i), .rp_ld(rp_ld), .rp_i(rp_i), .wptr_i(wptr_i),
    .test_i(test_i), .rdata(rdata), .rptr_o(rptr_o), .ctrl_o(ctrl_o)
  );

  assert_drive_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (addr_hit && cmd.rd));
  assert_quiet_alt_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    if_sel |=> !wr_stb);
endmodule

// File: tb/hreg_serial_slave_bench.sv
module hreg_serial_slave_bench;
  localparam int CB = 36;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0;
  logic if_sel = 0, chip_role = 0, dec_busy = 0;
  logic sck = 0, ss_n = 1, si = 0;
  logic so, so_oe;
  logic [111:0] info_i = '0;
  logic stat_we = 0;
  logic [7:0] stat0_i = 0, stat1_i = 0, test_i = 0;
  logic rp_ld = 0;
  logic [15:0] rp_i = 0, wptr_i = 0, rptr_o;
  logic [8*CB-1:0] ctrl_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  ctrl_m [CB];
  logic [7:0]  st0_m = 8'h03, st1_m = 8'h00;
  logic [15:0] rp_m = 0;

  always #5 clk = ~clk;

  hreg_serial_slave u_hreg_serial_slave (
    .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .chip_role(chip_role), .dec_busy(dec_busy),
    .sck(sck), .ss_n(ss_n), .si(si), .so(so), .so_oe(so_oe), .info_i(info_i),
    .stat_we(stat_we), .stat0_i(stat0_i), .stat1_i(stat1_i), .rp_ld(rp_ld), .rp_i(rp_i),
    .rptr_o(rptr_o), .wptr_i(wptr_i), .test_i(test_i), .ctrl_o(ctrl_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int loc);
    if (loc < 14) return info_i[8*loc +: 8];
    if (loc == 14) return st0_m;
    if (loc == 15) return st1_m;
    if (loc == 16) return rp_m[15:8];
    if (loc == 17) return rp_m[7:0];
    if (loc == 18) return wptr_i[15:8];
    if (loc == 19) return wptr_i[7:0];
    if (loc >= 20 && loc < 20 + CB) return ctrl_m[loc-20];
    if (loc == 20 + CB) return test_i;
    return 8'h00;
  endfunction

  function automatic string tag_of(input int loc);
    if (loc < 14) return "R8";
    if (loc < 16) return "R9";
    if (loc < 18) return "R6";
    if (loc < 20) return "R7";
    if (loc < 20 + CB) return "R5";
    return "R10";
  endfunction

  function automatic logic may_write(input int loc, input logic busy);
    return (loc >= 20 && loc < 20 + CB) || ((loc == 16 || loc == 17) && !busy);
  endfunction

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                      output logic [7:0] rb, output logic oe_any);
    rb = 0;
    oe_any = 0;
    ss_n = 0;
    wait_clk(HP);
    for (int b = 0; b < nbits; b++) begin
      si = (b < 8) ? cmd[7-b] : wd[15-b];
      wait_clk(HP);
      if (b >= 8) begin
        rb = {rb[6:0], so};
        oe_any = oe_any | so_oe;
      end
      sck = 1;
      wait_clk(HP);
      sck = 0;
    end
    wait_clk(HP);
    ss_n = 1;
    wait_clk(2 * HP);
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < CB; i++) chk(req, {24'd0, ctrl_o[8*i +: 8]}, {24'd0, ctrl_m[i]});
    chk(req, {16'd0, rptr_o}, {16'd0, rp_m});
  endtask

  // host read of a local address in the current window, checked against the model
  task automatic rd_check(input int loc, input string req);
    logic [7:0] rb;
    logic oe;
    xfer({1'b1, chip_role, 6'(loc)}, 8'h00, 16, rb, oe);
    chk("R4", {31'd0, oe}, 32'd1);
    chk(req, {24'd0, rb}, {24'd0, exp_byte(loc)});
  endtask

  task automatic wr_op(input int loc, input logic [7:0] d);
    logic [7:0] rb;
    logic oe;
    xfer({1'b0, chip_role, 6'(loc)}, d, 16, rb, oe);
    if (may_write(loc, dec_busy)) begin
      if (loc == 16) rp_m[15:8] = d;
      else if (loc == 17) rp_m[7:0] = d;
      else ctrl_m[loc-20] = d;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic oe;
    void'($urandom(32'd4711));
    for (int i = 0; i < CB; i++) ctrl_m[i] = 8'h00;
    for (int i = 0; i < 14; i++) info_i[8*i +: 8] = 8'($urandom);
    wptr_i = 16'h5AC3;
    test_i = 8'h96;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);

    // reset state
    check_state("R5");
    chk("R1", {31'd0, so_oe}, 32'd0);
    rd_check(14, "R9");
    rd_check(15, "R9");

    // full frame write then MSB-first read back
    wr_op(20, 8'hA5);
    check_state("R2");
    rd_check(20, "R5");
    wr_op(20 + CB - 1, 8'h81);
    rd_check(20 + CB - 1, "R5");
    rd_check(20 + CB, "R10");
    wr_op(20 + CB, 8'hFF);
    rd_check(20 + CB, "R10");
    wr_op(63, 8'h77);
    rd_check(63, "R10");

    // aborted frame: 12 bits only
    xfer({1'b0, chip_role, 6'd21}, 8'h3C, 12, rb, oe);
    check_state("R2");

    // alternative interface selected
    if_sel = 1;
    xfer({1'b0, chip_role, 6'd22}, 8'h44, 16, rb, oe);
    check_state("R1");
    xfer({1'b1, chip_role, 6'd20}, 8'h00, 16, rb, oe);
    chk("R1", {31'd0, oe}, 32'd0);
    if_sel = 0;

    // read pointer permission and decoder load
    dec_busy = 1;
    wr_op(16, 8'h12);
    check_state("R6");
    dec_busy = 0;
    wr_op(16, 8'h12);
    wr_op(17, 8'h34);
    check_state("R6");
    rp_i = 16'hBEEF;
    rp_ld = 1;
    wait_clk(1);
    rp_ld = 0;
    rp_m = 16'hBEEF;
    check_state("R6");
    rd_check(17, "R6");

    // status load and host write ignored
    stat0_i = 8'h5C;
    stat1_i = 8'h09;
    stat_we = 1;
    wait_clk(1);
    stat_we = 0;
    st0_m = 8'h5C;
    st1_m = 8'h09;
    wr_op(14, 8'h00);
    rd_check(14, "R9");
    rd_check(15, "R9");
    wr_op(3, 8'hEE);
    rd_check(3, "R8");
    rd_check(18, "R7");

    // random traffic in both roles
    for (int r = 0; r < 2; r++) begin
      chip_role = r[0];
      for (int t = 0; t < 110; t++) begin
        logic [5:0] loc;
        logic       other, rd;
        logic [7:0] d;
        loc = 6'($urandom);
        other = ($urandom % 4) == 0;
        rd = 1'($urandom);
        d = 8'($urandom);
        dec_busy = 1'($urandom);
        if (other) begin
          xfer({rd, ~chip_role, loc}, d, 16, rb, oe);
          chk("R3", {31'd0, oe}, 32'd0);
          check_state("R3");
        end else if (rd) begin
          rd_check(int'(loc), tag_of(int'(loc)));
        end else begin
          wr_op(int'(loc), d);
          check_state(tag_of(int'(loc)));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule